// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Selectable Saturation

This block is the multiply-accumulate engine of a small CPU datapath. Each accumulate strobe multiplies two signed 16-bit operands and adds the exact 32-bit product to an internal accumulator. The accumulator has a 10-bit high part and a 32-bit low part. A mode input picks how the sum is formed. In the clamping mode only the low 32 bits take part, and the sum is held at the signed limits when it would leave the range. In the wrapping mode all 42 bits take part, and the sum rolls over without any limit.

Software-visible transfers use one 32-bit port. Separate strobes load the high part or the low part, and a clear strobe zeroes the whole accumulator and the overflow flag. A store strobe copies either half into a registered read-back output, chosen by a select input. The high half is returned sign-extended. A sticky flag records any clamping event. Operands arrive already fetched on input ports.

Top module: `mac_unit`

## Requirements
- R1: The product of the two operands is their exact signed 32-bit product, including -32768 x -32768 = 0x40000000.
- R2: With `sat_mode`=1, an accumulate sets the low half to low + product. The result is limited to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow. The high half becomes the sign replication of the new low half.
- R3: `ovf` goes to 1 in the cycle after a clamping accumulate. It then stays 1 until a clear or reset.
- R4: With `sat_mode`=0, an accumulate adds the sign-extended product to the 42-bit value {high, low} modulo 2^42. `ovf` is unchanged.
- R5: A clear strobe sets both halves and `ovf` to zero. It overrides an accumulate or load strobe in the same cycle.
- R6: `ldh_go` loads `xfer_in[9:0]` into the high half, and `ldl_go` loads `xfer_in[31:0]` into the low half. Both may be given in the same cycle.
- R7: On a `st_go` edge, `rd_data` takes the low half (`st_hi`=0) or the high half sign-extended to 32 bits (`st_hi`=1). An accumulate is visible to a store issued in the next cycle. Without `st_go`, `rd_data` holds its value.
- R8: Changing `sat_mode` alone leaves the accumulator unchanged.
- R9: If an accumulate and a load are strobed in the same cycle, the load is ignored and the accumulate takes effect.
- R10: After reset the accumulator, `ovf` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sat_mode | input | 1 | 1: 32-bit clamping, 0: 42-bit wrapping |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| mac_go | input | 1 | Accumulate strobe |
| clr_go | input | 1 | Clear strobe |
| ldh_go | input | 1 | Load high half strobe |
| ldl_go | input | 1 | Load low half strobe |
| st_go | input | 1 | Store strobe |
| st_hi | input | 1 | Store selects high half when 1 |
| xfer_in | input | 32 | Transfer data for loads |
| rd_data | output | 32 | Registered store result |
| ovf | output | 1 | Sticky clamp flag |

## Verification
The bench builds the block with its default widths: 16-bit operands, a 32-bit low half and a 10-bit high half. With these widths the loads can place the accumulator right at each boundary. This brings the clamp at both signed limits within reach in one accumulate, as well as the carry from low into high and the wrap of the 42-bit value from its largest positive value to negative. The squared most-negative operand is also reachable, both on its own and as the step that pushes an accumulator into clamping.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OPW = 16;
  localparam int LOW = 32;
  localparam int HIW = 10;

  typedef struct packed {
    logic [LOW-1:0] val;
    logic           clamp;
  } sat_res_t;

  function automatic logic [LOW-1:0] mul_signed(input logic [OPW-1:0] a,
                                                input logic [OPW-1:0] b);
    logic signed [LOW-1:0] ae;
    logic signed [LOW-1:0] be;
    ae = LOW'(signed'(a));
    be = LOW'(signed'(b));
    return LOW'(ae * be);
  endfunction

  function automatic sat_res_t add_clamp(input logic [LOW-1:0] acc,
                                         input logic [LOW-1:0] p);
    logic [LOW:0] s;
    sat_res_t r;
    s = {acc[LOW-1], acc} + {p[LOW-1], p};
    r.clamp = s[LOW] ^ s[LOW-1];
    if (!r.clamp)     r.val = s[LOW-1:0];
    else if (s[LOW])  r.val = {1'b1, {(LOW-1){1'b0}}};
    else              r.val = {1'b0, {(LOW-1){1'b1}}};
    return r;
  endfunction
endpackage

// File: rtl/mac_mult.sv
module mac_mult import mac_pkg::*; #(
  parameter int OP_W = OPW,
  parameter int P_W  = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] a,
  input  logic [OP_W-1:0] b,
  output logic [P_W-1:0]  prod
);
  localparam logic [OP_W-1:0] MOST_NEG = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [P_W-1:0]  NEG_SQ   = {2'b01, {(P_W-2){1'b0}}};

  assign prod = P_W'(mul_signed(a, b));

  AST_PROD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (a == MOST_NEG && b == MOST_NEG) |-> (prod == NEG_SQ)); // R1
endmodule

// File: rtl/mac_accum.sv
module mac_accum import mac_pkg::*; #(
  parameter int LO_W = LOW,
  parameter int HI_W = HIW,
  localparam int FULL_W = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sat_mode,
  input  logic [LO_W-1:0] prod,
  input  logic            mac_go,
  input  logic            clr_go,
  input  logic            ldh_go,
  input  logic            ldl_go,
  input  logic [LO_W-1:0] xfer,
  output logic [HI_W-1:0] hi,
  output logic [LO_W-1:0] lo,
  output logic            ovf
);
  localparam logic [LO_W-1:0] MAX_POS = {1'b0, {(LO_W-1){1'b1}}};
  localparam logic [LO_W-1:0] MAX_NEG = {1'b1, {(LO_W-1){1'b0}}};

  sat_res_t          sat_r;
  logic [FULL_W-1:0] wrap_sum;
  logic              do_mac;
  logic              do_load;
  logic              clamp_evt;

  assign sat_r     = add_clamp(lo, prod);
  assign wrap_sum  = {hi, lo} + {{HI_W{prod[LO_W-1]}}, prod};
  assign do_mac    = mac_go && !clr_go;
  assign do_load   = (ldh_go || ldl_go) && !clr_go && !mac_go;
  assign clamp_evt = do_mac && sat_mode && sat_r.clamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi  <= '0;
      lo  <= '0;
      ovf <= 1'b0;
    end else if (clr_go) begin
      hi  <= '0;
      lo  <= '0;
      ovf <= 1'b0;
    end else if (do_mac) begin
      if (sat_mode) begin
        lo <= sat_r.val;
        hi <= {HI_W{sat_r.val[LO_W-1]}};
        if (sat_r.clamp) ovf <= 1'b1;
      end else begin
        {hi, lo} <= wrap_sum;
      end
    end else if (do_load) begin
      if (ldh_go) hi <= xfer[HI_W-1:0];
      if (ldl_go) lo <= xfer;
    end
  end

  AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_evt |=> (lo == MAX_POS || lo == MAX_NEG)); // R2
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (do_mac && sat_mode) |=> (hi == {HI_W{lo[LO_W-1]}})); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_go) |=> ovf); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_evt |=> ovf); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_go |=> (hi == '0 && lo == '0 && !ovf)); // R5
  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mac_go && !clr_go && !ldh_go && !ldl_go) |=> ($stable(hi) && $stable(lo))); // R8
endmodule

// File: rtl/mac_unit.sv
module mac_unit import mac_pkg::*; #(
  parameter int OP_W = OPW,
  parameter int LO_W = 2 * OP_W,
  parameter int HI_W = HIW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sat_mode,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  input  logic            mac_go,
  input  logic            clr_go,
  input  logic            ldh_go,
  input  logic            ldl_go,
  input  logic            st_go,
  input  logic            st_hi,
  input  logic [LO_W-1:0] xfer_in,
  output logic [LO_W-1:0] rd_data,
  output logic            ovf
);
  logic [LO_W-1:0] prod;
  logic [HI_W-1:0] acc_hi;
  logic [LO_W-1:0] acc_lo;
  logic [LO_W-1:0] hi_wide;

  mac_mult #(.OP_W(OP_W), .P_W(LO_W)) u_mult (
    .clk(clk), .rst_n(rst_n), .a(op_a), .b(op_b), .prod(prod)
  );

  mac_accum #(.LO_W(LO_W), .HI_W(HI_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .sat_mode(sat_mode), .prod(prod),
    .mac_go(mac_go), .clr_go(clr_go), .ldh_go(ldh_go), .ldl_go(ldl_go),
    .xfer(xfer_in), .hi(acc_hi), .lo(acc_lo), .ovf(ovf)
  );

  assign hi_wide = {{(LO_W-HI_W){acc_hi[HI_W-1]}}, acc_hi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (st_go) rd_data <= st_hi ? hi_wide : acc_lo;
  end

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !st_go |=> $stable(rd_data)); // R7
endmodule

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sat_mode = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        mac_go = 0, clr_go = 0, ldh_go = 0, ldl_go = 0, st_go = 0, st_hi = 0;
  logic [31:0] xfer_in = '0;
  logic [31:0] rd_data;
  logic        ovf;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mac_unit u0 (
    .clk(clk), .rst_n(rst_n), .sat_mode(sat_mode), .op_a(op_a), .op_b(op_b),
    .mac_go(mac_go), .clr_go(clr_go), .ldh_go(ldh_go), .ldl_go(ldl_go),
    .st_go(st_go), .st_hi(st_hi), .xfer_in(xfer_in), .rd_data(rd_data), .ovf(ovf)
  );

  typedef struct packed {
    logic        sat;
    logic [31:0] pre_hi;
    logic [31:0] pre_lo;
    logic [15:0] a;
    logic [15:0] b;
    logic [31:0] exp_hi;
    logic [31:0] exp_lo;
    logic        exp_ovf;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 32'h0,   32'h0,        16'd3,    16'd4,    32'h0,        32'd12,       1'b0}, // R2 plain
    '{1'b1, 32'h0,   32'h7FFFFFF0, 16'd2,    16'd16,   32'h0,        32'h7FFFFFFF, 1'b1}, // R2 +clamp
    '{1'b1, 32'h3FF, 32'h80000005, 16'hFFFF, 16'd16,   32'hFFFFFFFF, 32'h80000000, 1'b1}, // R2 -clamp
    '{1'b0, 32'h0,   32'hFFFFFFFF, 16'd1,    16'd1,    32'h1,        32'h0,        1'b0}, // R4 carry
    '{1'b0, 32'h1FF, 32'hFFFFFFFF, 16'd1,    16'd1,    32'hFFFFFE00, 32'h0,        1'b0}, // R4 wrap
    '{1'b1, 32'h0,   32'h0,        16'h8000, 16'h8000, 32'h0,        32'h40000000, 1'b0}, // R1
    '{1'b0, 32'h0,   32'h0,        16'h8000, 16'h7FFF, 32'hFFFFFFFF, 32'hC0008000, 1'b0}, // R1 R4
    '{1'b1, 32'h0,   32'h40000000, 16'h8000, 16'h8000, 32'h0,        32'h7FFFFFFF, 1'b1}  // R1 R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe_clr();
    @(negedge clk); clr_go = 1;
    @(negedge clk); clr_go = 0;
  endtask

  task automatic load(input logic [31:0] h, input logic [31:0] l);
    @(negedge clk); ldh_go = 1; ldl_go = 1; xfer_in = l;
    @(negedge clk); ldh_go = 0; ldl_go = 1; xfer_in = l;
    ldh_go = 1; ldl_go = 0; xfer_in = h;
    @(negedge clk); ldh_go = 0; ldl_go = 0;
  endtask

  task automatic do_mac(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk); mac_go = 1; op_a = a; op_b = b;
    @(negedge clk); mac_go = 0;
  endtask

  task automatic store(input logic hsel, output logic [31:0] v);
    @(negedge clk); st_go = 1; st_hi = hsel;
    @(negedge clk); st_go = 0;
    v = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rd_data", rd_data, 32'h0);
    check("R10 ovf", {31'b0, ovf}, 32'h0);
    rst_n = 1;
    store(1'b0, v); check("R10 lo", v, 32'h0);
    store(1'b1, v); check("R10 hi", v, 32'h0);

    for (int i = 0; i < 8; i++) begin
      strobe_clr();
      load(VECS[i].pre_hi, VECS[i].pre_lo);
      @(negedge clk); sat_mode = VECS[i].sat;
      do_mac(VECS[i].a, VECS[i].b);
      store(1'b1, v); check($sformatf("R2/R4 vec%0d hi", i), v, VECS[i].exp_hi);
      store(1'b0, v); check($sformatf("R2/R4 vec%0d lo", i), v, VECS[i].exp_lo);
      check($sformatf("R3 vec%0d ovf", i), {31'b0, ovf}, {31'b0, VECS[i].exp_ovf});
    end

    // R3 sticky across a non-clamping accumulate, then cleared (R5)
    do_mac(16'hFFFF, 16'd1);
    check("R3 sticky", {31'b0, ovf}, 32'h1);
    strobe_clr();
    check("R5 ovf cleared", {31'b0, ovf}, 32'h0);

    // R6 load high from low 10 bits, sign-extended on store
    load(32'hABCD_0155, 32'h1234_5678);
    store(1'b1, v); check("R6 hi", v, 32'h0000_0155);
    store(1'b0, v); check("R6 lo", v, 32'h1234_5678);

    // R5 clear beats accumulate and load
    @(negedge clk); clr_go = 1; mac_go = 1; ldl_go = 1; op_a = 16'd5; op_b = 16'd5; xfer_in = 32'h55;
    @(negedge clk); clr_go = 0; mac_go = 0; ldl_go = 0;
    store(1'b0, v); check("R5 lo zero", v, 32'h0);
    store(1'b1, v); check("R5 hi zero", v, 32'h0);

    // R9 accumulate beats load
    @(negedge clk); sat_mode = 0; mac_go = 1; ldl_go = 1; op_a = 16'd7; op_b = 16'd6; xfer_in = 32'h999;
    @(negedge clk); mac_go = 0; ldl_go = 0;
    store(1'b0, v); check("R9 mac wins", v, 32'd42);

    // R7 accumulate visible to store in the next cycle; back-to-back accumulates
    @(negedge clk); mac_go = 1; op_a = 16'd10; op_b = 16'hFFFE;
    @(negedge clk); mac_go = 0; st_go = 1; st_hi = 0;
    @(negedge clk); st_go = 0;
    check("R7 next-cycle store", rd_data, 32'd22);
    @(negedge clk); @(negedge clk);
    check("R7 hold", rd_data, 32'd22);

    // R8 mode change alone keeps accumulator
    load(32'h3FF, 32'h8000_0000);
    @(negedge clk); sat_mode = 1;
    @(negedge clk); sat_mode = 0;
    @(negedge clk); sat_mode = 1;
    store(1'b1, v); check("R8 hi", v, 32'hFFFF_FFFF);
    store(1'b0, v); check("R8 lo", v, 32'h8000_0000);
    check("R8 ovf", {31'b0, ovf}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule